// File: doc/BRIEF.md
# Jacobian Point Addition Sequencer

This block adds two elliptic-curve points over a prime field, both supplied in Jacobian projective form (X, Y, Z with affine x = X/Z², y = Y/Z³). It is meant to be used as the addition step of a Montgomery ladder, where the two working points always differ by the base point. A one-cycle start pulse captures the six input coordinates. The block then runs a fixed program of 23 modular additions, subtractions and multiplications on one shared modular arithmetic unit, keeping intermediate values in eight temporaries. It returns the three result coordinates together with a one-cycle done pulse.

The ladder's invariant rules out equal or opposite operands, so there is no doubling or negation path. The only special cases are inputs at infinity, which are marked by a zero Z coordinate. Both Z values are tested when the operands are captured. The full program always runs to the end, and only then is the output chosen: the computed sum, Q when Pz is zero, or P when Qz is zero. As a result the latency is the same for every operand.

Top module: `jac_point_add`

## Requirements
- R1: `done_o` is high for exactly one cycle. It rises 23 clock cycles after the rising edge at which `start_i` was sampled high while the block was idle, and this count is the same for every operand value, including the bypass cases.
- R2: For two distinct, non-opposite finite points, the result converted to affine form (X/Z², Y/Z³ mod MOD) equals the affine sum P + Q.
- R3: Let U1 = Px·Qz², U2 = Qx·Pz² and H = U2 − U1, all mod MOD. When both Z inputs are non-zero, `r_z_o` equals Pz·Qz·H mod MOD.
- R4: Let S1 = Py·Qz³, S2 = Qy·Pz³ and R = S2 − S1. When both Z inputs are non-zero, `r_x_o` equals R² − H³ − 2·U1·H² mod MOD, and `r_y_o` equals (U1·H² − r_x_o)·R − S1·H³ mod MOD.
- R5: When the captured Pz is zero, the outputs equal the captured Qx, Qy, Qz bit for bit.
- R6: When the captured Pz is non-zero and the captured Qz is zero, the outputs equal the captured Px, Py, Pz bit for bit.
- R7: A `start_i` pulse that arrives while a computation is running has no effect. The coordinate inputs are sampled only at the edge where a start is accepted, so later changes to them do not alter the result.
- R8: The outputs change only at the edge that raises `done_o`, and they hold their value from then until the next completion.
- R9: After reset, `done_o` is low and all three output coordinates are zero.
- R10: When every input coordinate is below MOD, every output coordinate is below MOD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| p_x_i | input | W | X coordinate of P |
| p_y_i | input | W | Y coordinate of P |
| p_z_i | input | W | Z coordinate of P (zero means infinity) |
| q_x_i | input | W | X coordinate of Q |
| q_y_i | input | W | Y coordinate of Q |
| q_z_i | input | W | Z coordinate of Q (zero means infinity) |
| r_x_o | output | W | X coordinate of the result |
| r_y_o | output | W | Y coordinate of the result |
| r_z_o | output | W | Z coordinate of the result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The range assertion relies on every captured coordinate already being reduced below the modulus. The bypass assertions assume that a zero Z really does mark infinity, and the formulas are only meaningful when the two finite operands are neither equal nor opposite. The stimulus stays inside these limits. It builds finite operands by lifting distinct small multiples of one curve point with a random non-zero scale factor below the modulus. Operands at infinity get random reduced X and Y with Z forced to zero, and it never makes both Z values zero in the same operation. Input values scrambled after a start are also kept reduced, but those are never captured.

// File: rtl/jac_add_pkg.sv
package jac_add_pkg;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } alu_op_e;

  localparam int IDX_W  = 5;
  localparam int N_REGS = 17;
  localparam int N_IN   = 6;

  // storage slots: temporaries, captured inputs, result coordinates
  localparam logic [IDX_W-1:0] RG_T1 = 5'd0;
  localparam logic [IDX_W-1:0] RG_T2 = 5'd1;
  localparam logic [IDX_W-1:0] RG_T3 = 5'd2;
  localparam logic [IDX_W-1:0] RG_T4 = 5'd3;
  localparam logic [IDX_W-1:0] RG_T5 = 5'd4;
  localparam logic [IDX_W-1:0] RG_T6 = 5'd5;
  localparam logic [IDX_W-1:0] RG_T7 = 5'd6;
  localparam logic [IDX_W-1:0] RG_T8 = 5'd7;
  localparam logic [IDX_W-1:0] RG_PX = 5'd8;
  localparam logic [IDX_W-1:0] RG_PY = 5'd9;
  localparam logic [IDX_W-1:0] RG_PZ = 5'd10;
  localparam logic [IDX_W-1:0] RG_QX = 5'd11;
  localparam logic [IDX_W-1:0] RG_QY = 5'd12;
  localparam logic [IDX_W-1:0] RG_QZ = 5'd13;
  localparam logic [IDX_W-1:0] RG_RX = 5'd14;
  localparam logic [IDX_W-1:0] RG_RY = 5'd15;
  localparam logic [IDX_W-1:0] RG_RZ = 5'd16;

  localparam int N_STEPS = 23;
  localparam int STEP_W  = $clog2(N_STEPS);

  typedef struct packed {
    alu_op_e          op;
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] dst;
  } uop_t;

  function automatic uop_t mk_uop(alu_op_e op, logic [IDX_W-1:0] a,
                                  logic [IDX_W-1:0] b, logic [IDX_W-1:0] d);
    uop_t u;
    u.op    = op;
    u.src_a = a;
    u.src_b = b;
    u.dst   = d;
    return u;
  endfunction

endpackage

// File: rtl/jac_mod_alu.sv
module jac_mod_alu
  import jac_add_pkg::*;
#(
  parameter int         W   = 16,
  parameter logic [W-1:0] MOD = 16'd65521
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);

  localparam int PW = 2 * W;
  localparam logic [PW-1:0] MOD_P = {{W{1'b0}}, MOD};
  localparam logic [W:0]    MOD_S = {1'b0, MOD};

  logic [PW-1:0] prod, prod_red;
  logic [W:0]    sum, sum_red;
  logic [W-1:0]  diff;

  always_comb begin
    prod     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    prod_red = prod % MOD_P;
    sum      = {1'b0, a_i} + {1'b0, b_i};
    sum_red  = (sum >= MOD_S) ? (sum - MOD_S) : sum;
    // operands assumed reduced, so one correction suffices
    diff     = (a_i >= b_i) ? (a_i - b_i) : (a_i + (MOD - b_i));
  end

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = sum_red[W-1:0];
      ALU_SUB: y_o = diff;
      ALU_MUL: y_o = prod_red[W-1:0];
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/jac_add_prog.sv
module jac_add_prog
  import jac_add_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output uop_t              uop_o
);

  always_comb begin
    unique case (step_i)
      // cross-normalise both operands
      5'd0:  uop_o = mk_uop(ALU_MUL, RG_PZ, RG_PZ, RG_T1); // Pz^2
      5'd1:  uop_o = mk_uop(ALU_MUL, RG_QZ, RG_QZ, RG_T2); // Qz^2
      5'd2:  uop_o = mk_uop(ALU_MUL, RG_PZ, RG_T1, RG_T3); // Pz^3
      5'd3:  uop_o = mk_uop(ALU_MUL, RG_QZ, RG_T2, RG_T4); // Qz^3
      5'd4:  uop_o = mk_uop(ALU_MUL, RG_PX, RG_T2, RG_T5); // U1
      5'd5:  uop_o = mk_uop(ALU_MUL, RG_QX, RG_T1, RG_T2); // U2
      5'd6:  uop_o = mk_uop(ALU_MUL, RG_PY, RG_T4, RG_T6); // S1
      5'd7:  uop_o = mk_uop(ALU_MUL, RG_QY, RG_T3, RG_T4); // S2
      5'd8:  uop_o = mk_uop(ALU_SUB, RG_T2, RG_T5, RG_T7); // H
      5'd9:  uop_o = mk_uop(ALU_SUB, RG_T4, RG_T6, RG_T8); // R
      // result Z
      5'd10: uop_o = mk_uop(ALU_MUL, RG_PZ, RG_QZ, RG_T1);
      5'd11: uop_o = mk_uop(ALU_MUL, RG_T7, RG_T1, RG_RZ);
      // result X
      5'd12: uop_o = mk_uop(ALU_MUL, RG_T8, RG_T8, RG_T2); // R^2
      5'd13: uop_o = mk_uop(ALU_MUL, RG_T7, RG_T7, RG_T3); // H^2
      5'd14: uop_o = mk_uop(ALU_MUL, RG_T7, RG_T3, RG_T4); // H^3
      5'd15: uop_o = mk_uop(ALU_SUB, RG_T2, RG_T4, RG_T1);
      5'd16: uop_o = mk_uop(ALU_MUL, RG_T5, RG_T3, RG_T2); // U1*H^2
      5'd17: uop_o = mk_uop(ALU_ADD, RG_T2, RG_T2, RG_T3); // doubled by self-add
      5'd18: uop_o = mk_uop(ALU_SUB, RG_T1, RG_T3, RG_RX);
      // result Y
      5'd19: uop_o = mk_uop(ALU_SUB, RG_T2, RG_RX, RG_T1);
      5'd20: uop_o = mk_uop(ALU_MUL, RG_T1, RG_T8, RG_T2);
      5'd21: uop_o = mk_uop(ALU_MUL, RG_T6, RG_T4, RG_T3); // S1*H^3
      5'd22: uop_o = mk_uop(ALU_SUB, RG_T2, RG_T3, RG_RY);
      default: uop_o = mk_uop(ALU_ADD, RG_T1, RG_T1, RG_T1);
    endcase
  end

endmodule

// File: rtl/jac_add_regs.sv
module jac_add_regs
  import jac_add_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     load_data_i [N_IN],
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     regs_o [N_REGS]
);

  localparam int IN_BASE = int'(RG_PX);
  localparam int IN_LAST = int'(RG_QZ);

  for (genvar g = 0; g < N_REGS; g++) begin : g_slot
    if (g >= IN_BASE && g <= IN_LAST) begin : g_in
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     regs_o[g] <= '0;
        else if (load_i)                                 regs_o[g] <= load_data_i[g-IN_BASE];
        else if (wr_en_i && wr_idx_i == IDX_W'(g))       regs_o[g] <= wr_data_i;
      end
    end else begin : g_work
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     regs_o[g] <= '0;
        else if (wr_en_i && wr_idx_i == IDX_W'(g))       regs_o[g] <= wr_data_i;
      end
    end
  end

endmodule

// File: rtl/jac_point_add.sv
module jac_point_add
  import jac_add_pkg::*;
#(
  parameter int           W   = 16,
  parameter logic [W-1:0] MOD = 16'd65521
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] p_x_i,
  input  logic [W-1:0] p_y_i,
  input  logic [W-1:0] p_z_i,
  input  logic [W-1:0] q_x_i,
  input  logic [W-1:0] q_y_i,
  input  logic [W-1:0] q_z_i,
  output logic [W-1:0] r_x_o,
  output logic [W-1:0] r_y_o,
  output logic [W-1:0] r_z_o,
  output logic         done_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  logic              run_q;
  logic [STEP_W-1:0] step_q;
  logic              pz_zero_q, qz_zero_q;
  logic              done_q;
  logic [W-1:0]      rx_q, ry_q, rz_q;

  logic              accept, last;
  uop_t              uop;
  logic [W-1:0]      regs [N_REGS];
  logic [W-1:0]      in_vec [N_IN];
  logic [W-1:0]      opa, opb, res;
  logic [W-1:0]      sel_x, sel_y, sel_z;

  assign accept = start_i && !run_q;
  assign last   = run_q && (step_q == LAST_STEP);

  assign in_vec[0] = p_x_i;
  assign in_vec[1] = p_y_i;
  assign in_vec[2] = p_z_i;
  assign in_vec[3] = q_x_i;
  assign in_vec[4] = q_y_i;
  assign in_vec[5] = q_z_i;

  jac_add_prog i_prog (
    .step_i (step_q),
    .uop_o  (uop)
  );

  assign opa = regs[uop.src_a];
  assign opb = regs[uop.src_b];

  jac_mod_alu #(.W(W), .MOD(MOD)) i_alu (
    .op_i (uop.op),
    .a_i  (opa),
    .b_i  (opb),
    .y_o  (res)
  );

  jac_add_regs #(.W(W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_data_i (in_vec),
    .wr_en_i     (run_q),
    .wr_idx_i    (uop.dst),
    .wr_data_i   (res),
    .regs_o      (regs)
  );

  // infinity bypass chosen only after the full program
  always_comb begin
    if (pz_zero_q) begin
      sel_x = regs[RG_QX];
      sel_y = regs[RG_QY];
      sel_z = regs[RG_QZ];
    end else if (qz_zero_q) begin
      sel_x = regs[RG_PX];
      sel_y = regs[RG_PY];
      sel_z = regs[RG_PZ];
    end else begin
      sel_x = regs[RG_RX];
      sel_y = res;
      sel_z = regs[RG_RZ];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      step_q    <= '0;
      pz_zero_q <= 1'b0;
      qz_zero_q <= 1'b0;
    end else if (accept) begin
      run_q     <= 1'b1;
      step_q    <= '0;
      pz_zero_q <= (p_z_i == '0);
      qz_zero_q <= (q_z_i == '0);
    end else if (run_q) begin
      step_q <= step_q + 1'b1;
      if (last) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rx_q   <= '0;
      ry_q   <= '0;
      rz_q   <= '0;
    end else begin
      done_q <= last;
      if (last) begin
        rx_q <= sel_x;
        ry_q <= sel_y;
        rz_q <= sel_z;
      end
    end
  end

  assign r_x_o  = rx_q;
  assign r_y_o  = ry_q;
  assign r_z_o  = rz_q;
  assign done_o = done_q;

endmodule

// File: rtl/jac_point_add_chk.sv
module jac_point_add_chk
  import jac_add_pkg::*;
#(
  parameter int           W   = 16,
  parameter logic [W-1:0] MOD = 16'd65521
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] p_x_i,
  input logic [W-1:0] p_y_i,
  input logic [W-1:0] p_z_i,
  input logic [W-1:0] q_x_i,
  input logic [W-1:0] q_y_i,
  input logic [W-1:0] q_z_i,
  input logic [W-1:0] r_x_o,
  input logic [W-1:0] r_y_o,
  input logic [W-1:0] r_z_o,
  input logic         done_o
);

  localparam int CW = $clog2(N_STEPS + 1);
  localparam logic [CW-1:0] END_CNT = CW'(N_STEPS - 1);

  logic          run_c;
  logic [CW-1:0] cnt_c;
  logic [W-1:0]  c_px, c_py, c_pz, c_qx, c_qy, c_qz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_c <= 1'b0;
      cnt_c <= '0;
      c_px <= '0; c_py <= '0; c_pz <= '0;
      c_qx <= '0; c_qy <= '0; c_qz <= '0;
    end else if (run_c) begin
      cnt_c <= cnt_c + 1'b1;
      if (cnt_c == END_CNT) run_c <= 1'b0;
    end else if (start_i) begin
      run_c <= 1'b1;
      cnt_c <= '0;
      c_px <= p_x_i; c_py <= p_y_i; c_pz <= p_z_i;
      c_qx <= q_x_i; c_qy <= q_y_i; c_qz <= q_z_i;
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_due_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_c && cnt_c == END_CNT) |=> done_o);

  p_done_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_c && cnt_c == END_CNT) |=> !done_o);

  p_bypass_q_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_pz == '0) |-> (r_x_o == c_qx && r_y_o == c_qy && r_z_o == c_qz));

  p_bypass_p_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && c_pz != '0 && c_qz == '0) |->
      (r_x_o == c_px && r_y_o == c_py && r_z_o == c_pz));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(r_x_o) && $stable(r_y_o) && $stable(r_z_o)));

  p_reduced_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (r_x_o < MOD && r_y_o < MOD && r_z_o < MOD));

endmodule

bind jac_point_add jac_point_add_chk #(.W(W), .MOD(MOD)) i_chk (.*);

// File: tb/test_jac_point_add.sv
module test_jac_point_add;
  import jac_add_pkg::*;

  localparam int     W   = 16;
  localparam longint PM  = 65521;
  localparam longint CA  = 2;
  localparam int     LAT = N_STEPS;

  logic         clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [W-1:0] p_x_i = '0, p_y_i = '0, p_z_i = '0;
  logic [W-1:0] q_x_i = '0, q_y_i = '0, q_z_i = '0;
  logic [W-1:0] r_x_o, r_y_o, r_z_o;
  logic         done_o;

  always #2 clk = ~clk;

  jac_point_add #(.W(W), .MOD(16'd65521)) i_jac_point_add (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .p_x_i(p_x_i), .p_y_i(p_y_i), .p_z_i(p_z_i),
    .q_x_i(q_x_i), .q_y_i(q_y_i), .q_z_i(q_z_i),
    .r_x_o(r_x_o), .r_y_o(r_y_o), .r_z_o(r_z_o), .done_o(done_o)
  );

  typedef struct {
    int     mode; // 0 sum, 1 pass Q, 2 pass P
    longint x, y, z, ax, ay;
  } exp_t;

  int     n_chk = 0, n_err = 0;
  bit     finished = 1'b0;
  exp_t   exp_q[$];
  exp_t   last_e;
  longint ptx [1:40];
  longint pty [1:40];

  function automatic longint mm(longint a, longint b); return (a * b) % PM; endfunction
  function automatic longint ma(longint a, longint b); return (a + b) % PM; endfunction
  function automatic longint ms(longint a, longint b); return (a - b + PM) % PM; endfunction
  function automatic longint minv(longint a);
    longint r = 1, base = a % PM, e = PM - 2;
    while (e > 0) begin
      if (e[0]) r = mm(r, base);
      base = mm(base, base);
      e = e >> 1;
    end
    return r;
  endfunction

  task automatic aff_add(input longint x1, y1, x2, y2, output longint x3, y3);
    longint lam = mm(ms(y2, y1), minv(ms(x2, x1)));
    x3 = ms(ms(mm(lam, lam), x1), x2);
    y3 = ms(mm(lam, ms(x1, x3)), y1);
  endtask

  task automatic aff_dbl(input longint x1, y1, output longint x3, y3);
    longint lam = mm(ma(mm(3, mm(x1, x1)), CA), minv(mm(2, y1)));
    x3 = ms(ms(mm(lam, lam), x1), x1);
    y3 = ms(mm(lam, ms(x1, x3)), y1);
  endtask

  function automatic exp_t jac_ref(longint px, py, pz, qx, qy, qz);
    exp_t e;
    longint pz2 = mm(pz, pz), qz2 = mm(qz, qz);
    longint u1 = mm(px, qz2), u2 = mm(qx, pz2);
    longint s1 = mm(py, mm(qz, qz2)), s2 = mm(qy, mm(pz, pz2));
    longint h = ms(u2, u1), r = ms(s2, s1);
    longint h2 = mm(h, h), h3 = mm(h, mm(h, h));
    longint u1h2 = mm(u1, h2);
    e.mode = 0;
    e.z = mm(mm(pz, qz), h);
    e.x = ms(ms(mm(r, r), h3), ma(u1h2, u1h2));
    e.y = ms(mm(ms(u1h2, e.x), r), mm(s1, h3));
    e.ax = 0;
    e.ay = 0;
    return e;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // cycle reference model for completion timing
  bit m_busy = 1'b0, m_due = 1'b0;
  int m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 1'b0;
      m_due  = 1'b0;
    end else begin
      m_due = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_busy = 1'b0;
          m_due  = 1'b1;
        end
      end else if (start_i) begin
        m_busy = 1'b1;
        m_cnt  = 0;
      end
    end
  end

  always @(negedge clk) begin : mon
    exp_t   e;
    longint zi, ax, ay;
    if (rst_ni && !finished) begin
      check(done_o === m_due, "R1 done timing", longint'(done_o), longint'(m_due));
      if (m_due) begin
        if (exp_q.size() == 0) check(1'b0, "R1 unexpected completion", 1, 0);
        else begin
          e = exp_q.pop_front();
          last_e = e;
          check(r_x_o < PM && r_y_o < PM && r_z_o < PM, "R10 reduced", longint'(r_x_o), PM);
          if (e.mode == 0) begin
            check(r_z_o == e.z, "R3 Z", longint'(r_z_o), e.z);
            check(r_x_o == e.x, "R4 X", longint'(r_x_o), e.x);
            check(r_y_o == e.y, "R4 Y", longint'(r_y_o), e.y);
            zi = minv(longint'(r_z_o));
            ax = mm(longint'(r_x_o), mm(zi, zi));
            ay = mm(longint'(r_y_o), mm(zi, mm(zi, zi)));
            check(ax == e.ax, "R2 affine x", ax, e.ax);
            check(ay == e.ay, "R2 affine y", ay, e.ay);
          end else begin
            check(r_x_o == e.x && r_y_o == e.y && r_z_o == e.z,
                  (e.mode == 1) ? "R5 pass Q" : "R6 pass P", longint'(r_x_o), e.x);
          end
        end
      end
    end
  end

  task automatic scramble();
    p_x_i = W'($urandom_range(65520, 0)); p_y_i = W'($urandom_range(65520, 0));
    p_z_i = W'($urandom_range(65520, 0)); q_x_i = W'($urandom_range(65520, 0));
    q_y_i = W'($urandom_range(65520, 0)); q_z_i = W'($urandom_range(65520, 0));
  endtask

  // caller is at a falling edge; returns one falling edge later
  task automatic issue(longint px, py, pz, qx, qy, qz, bit push, int mode,
                       longint ax, ay);
    exp_t e;
    p_x_i = W'(px); p_y_i = W'(py); p_z_i = W'(pz);
    q_x_i = W'(qx); q_y_i = W'(qy); q_z_i = W'(qz);
    start_i = 1'b1;
    if (push) begin
      if (mode == 0) begin
        e = jac_ref(px, py, pz, qx, qy, qz);
        e.ax = ax;
        e.ay = ay;
      end else begin
        e.mode = mode;
        e.x = (mode == 1) ? qx : px;
        e.y = (mode == 1) ? qy : py;
        e.z = (mode == 1) ? qz : pz;
        e.ax = 0;
        e.ay = 0;
      end
      exp_q.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b0;
    scramble(); // R7: later input changes must not matter
  endtask

  task automatic issue_sum(int i, int j, bit push);
    longint lp = longint'($urandom_range(65520, 1));
    longint lq = longint'($urandom_range(65520, 1));
    longint ax, ay;
    aff_add(ptx[i], pty[i], ptx[j], pty[j], ax, ay);
    issue(mm(ptx[i], mm(lp, lp)), mm(pty[i], mm(lp, mm(lp, lp))), lp,
          mm(ptx[j], mm(lq, lq)), mm(pty[j], mm(lq, mm(lq, lq))), lq,
          push, 0, ax, ay);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    longint lq;
    ptx[1] = 5;
    pty[1] = 7;
    aff_dbl(ptx[1], pty[1], ptx[2], pty[2]);
    for (int k = 3; k <= 40; k++) aff_add(ptx[k-1], pty[k-1], ptx[1], pty[1], ptx[k], pty[k]);

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R9 reset done", longint'(done_o), 0);
    check(r_x_o == '0, "R9 reset x", longint'(r_x_o), 0);
    check(r_y_o == '0, "R9 reset y", longint'(r_y_o), 0);
    check(r_z_o == '0, "R9 reset z", longint'(r_z_o), 0);

    // R2 R3 R4: distinct finite points in random projective scale
    for (int k = 0; k < 10; k++) begin
      issue_sum(k + 1, 20 + 2 * k, 1'b1);
      repeat (LAT + 2) @(negedge clk);
    end

    // R5: P at infinity
    for (int k = 0; k < 3; k++) begin
      lq = longint'($urandom_range(65520, 1));
      issue(longint'($urandom_range(65520, 0)), longint'($urandom_range(65520, 0)), 0,
            mm(ptx[k+5], mm(lq, lq)), mm(pty[k+5], mm(lq, mm(lq, lq))), lq, 1'b1, 1, 0, 0);
      repeat (LAT + 2) @(negedge clk);
    end

    // R6: Q at infinity
    for (int k = 0; k < 3; k++) begin
      lq = longint'($urandom_range(65520, 1));
      issue(mm(ptx[k+9], mm(lq, lq)), mm(pty[k+9], mm(lq, mm(lq, lq))), lq,
            longint'($urandom_range(65520, 0)), longint'($urandom_range(65520, 0)), 0,
            1'b1, 2, 0, 0);
      repeat (LAT + 2) @(negedge clk);
    end

    // R7: start while busy is ignored
    issue_sum(3, 17, 1'b1);
    repeat (5) @(negedge clk);
    issue_sum(4, 33, 1'b0);
    repeat (LAT) @(negedge clk);

    // R8: outputs hold while inputs move
    for (int k = 0; k < 10; k++) begin
      scramble();
      @(negedge clk);
    end
    check(r_x_o == last_e.x, "R8 hold x", longint'(r_x_o), last_e.x);
    check(r_y_o == last_e.y, "R8 hold y", longint'(r_y_o), last_e.y);
    check(r_z_o == last_e.z, "R8 hold z", longint'(r_z_o), last_e.z);

    // R1: new start in the same cycle as done
    issue_sum(6, 25, 1'b1);
    repeat (LAT) @(negedge clk);
    check(done_o == 1'b1, "R1 done before back-to-back", longint'(done_o), 1);
    issue_sum(7, 29, 1'b1);
    repeat (LAT + 4) @(negedge clk);
    check(exp_q.size() == 0, "R1 all completions seen", longint'(exp_q.size()), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule